// File: doc/BRIEF.md
# Multi-Pad Serial Gamepad Poller

This block reads the buttons of one or more serial-shift gamepads without pause. The pads follow the usual 16-bit console type. Every pad shares one load strobe and one shift clock that the block drives, and each pad returns its button word on its own serial line. All pads are shifted in lockstep. The block samples every line in the same system cycle and presents each button as a static parallel vector with one bit per pad. The vector changes only when a complete frame has arrived.

All protocol timing comes from a base unit of about 6 µs. A parameter gives this unit as a count of system clocks. For example, a 20 MHz system clock needs a value of 120. A frame consists of:
- one idle unit;
- a load strobe two units wide;
- sixteen shift-clock pulses, each low for one unit and high for one unit.

The next frame follows straight away, so a frame lasts 35 units. Parameters set the number of pads, the active level of the asynchronous reset and the active level of the button outputs.

Top module: `gamepad_poller`

## Requirements
- R1: While reset is asserted and after its release, before the first frame commits, every button output sits at its released level. The released level is 0 when OUT_ACTIVE_HIGH=1 and 1 when OUT_ACTIVE_HIGH=0. `pad_load` is low and `pad_shift_clk` is high.
- R2: `pad_load` is high for exactly 2*TICKS_PER_UNIT system cycles in every frame.
- R3: Each frame carries exactly 16 shift-clock pulses, and the clock rests high. Each low phase lasts TICKS_PER_UNIT cycles. A high phase between two pulses lasts TICKS_PER_UNIT cycles. The high run that spans the frame end, the idle unit and the load lasts 4*TICKS_PER_UNIT cycles. The clock falls in the same cycle that `pad_load` falls, and it is never low while `pad_load` is high.
- R4: Consecutive rising edges of `pad_load` are 35*TICKS_PER_UNIT system cycles apart.
- R5: The word bit with index k (k = 0..15) is the value the data line holds during the k-th low phase. The block samples it at the system edge where `pad_shift_clk` rises. The button order is: bit 0 B, 1 Y, 2 select, 3 start, 4 up, 5 down, 6 left, 7 right, 8 A, 9 X, 10 L, 11 R.
- R6: A 0 on a data line means pressed. With OUT_ACTIVE_HIGH=1 a pressed button drives its output bit to 1. With OUT_ACTIVE_HIGH=0 it drives it to 0.
- R7: `pad_serial[i]` drives only bit i of every button output, and the pads are independent.
- R8: All button outputs change together, one system cycle after the 16th sample of a frame. Until then they hold the previous frame's values, including through the whole of the next frame.
- R9: Word bits 12 to 15 have no effect on any output.
- R10: Reset acts asynchronously, at the level given by RESET_ACTIVE_HIGH (1: high asserts, 0: low asserts). When asserted mid-frame, it returns the outputs to the R1 state without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock, rising edge |
| sys_rst | input | 1 | Asynchronous reset, polarity set by RESET_ACTIVE_HIGH |
| pad_serial | input | NUM_PADS | One serial data line per pad, 0 = pressed |
| pad_load | output | 1 | Shared load strobe to all pads |
| pad_shift_clk | output | 1 | Shared shift clock to all pads, idles high |
| key_b | output | NUM_PADS | B button, one bit per pad |
| key_y | output | NUM_PADS | Y button |
| key_select | output | NUM_PADS | Select button |
| key_start | output | NUM_PADS | Start button |
| key_up | output | NUM_PADS | Pad up |
| key_down | output | NUM_PADS | Pad down |
| key_left | output | NUM_PADS | Pad left |
| key_right | output | NUM_PADS | Pad right |
| key_a | output | NUM_PADS | A button |
| key_x | output | NUM_PADS | X button |
| key_l | output | NUM_PADS | Left shoulder |
| key_r | output | NUM_PADS | Right shoulder |

## Verification
The bench builds the block with NUM_PADS=3, TICKS_PER_UNIT=3, RESET_ACTIVE_HIGH=0 and OUT_ACTIVE_HIGH=1. Three pads are enough to show that the lanes stay separate: a walking pressed bit is set to a different button on each pad in the same frame. A base unit of three clocks makes a frame only 105 cycles long, so many button patterns fit in a short run. It also keeps the unit long enough that the measured low, high, load and period lengths tell an off-by-one counter apart from a correct one. The active-low reset allows an asynchronous reset in the middle of a frame, which is checked between clock edges.

// File: rtl/gp_poll_pkg.sv
package gp_poll_pkg;
   localparam int unsigned FRAME_BITS = 16;
   localparam int unsigned KEY_COUNT  = 12;
   localparam int unsigned LOAD_UNITS = 2;
   localparam int unsigned BITCNT_W   = $clog2(FRAME_BITS);
   localparam int unsigned UNITCNT_W  = $clog2(LOAD_UNITS + 1);

   localparam int unsigned KEY_B      = 0;
   localparam int unsigned KEY_Y      = 1;
   localparam int unsigned KEY_SELECT = 2;
   localparam int unsigned KEY_START  = 3;
   localparam int unsigned KEY_UP     = 4;
   localparam int unsigned KEY_DOWN   = 5;
   localparam int unsigned KEY_LEFT   = 6;
   localparam int unsigned KEY_RIGHT  = 7;
   localparam int unsigned KEY_A      = 8;
   localparam int unsigned KEY_X      = 9;
   localparam int unsigned KEY_L      = 10;
   localparam int unsigned KEY_R      = 11;

   typedef enum logic [1:0] {
      PH_REST     = 2'd0,
      PH_LOAD     = 2'd1,
      PH_SHIFT_LO = 2'd2,
      PH_SHIFT_HI = 2'd3
   } phase_t;
endpackage

// File: rtl/gp_timebase.sv
module gp_timebase #(
   parameter int unsigned TICKS_PER_UNIT = 120
) (
   input  logic clk,
   input  logic arst,
   output logic tick_o
);
   localparam int unsigned CW = $clog2(TICKS_PER_UNIT);
   localparam logic [CW-1:0] LAST = CW'(TICKS_PER_UNIT - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or posedge arst) begin
      if (arst) begin
         cnt_q <= '0;
      end else if (cnt_q == LAST) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign tick_o = (cnt_q == LAST);

   // R4
   tick_spacing_chk: assert property (@(posedge clk) disable iff (arst)
      tick_o |=> !tick_o);
endmodule

// File: rtl/gp_sequencer.sv
module gp_sequencer
   import gp_poll_pkg::*;
(
   input  logic clk,
   input  logic arst,
   input  logic tick_i,
   output logic load_o,
   output logic shclk_o,
   output logic sample_o,
   output logic last_o
);
   localparam logic [BITCNT_W-1:0]  LAST_BIT  = BITCNT_W'(FRAME_BITS - 1);
   localparam logic [UNITCNT_W-1:0] LAST_UNIT = UNITCNT_W'(LOAD_UNITS - 1);

   phase_t                 ph_q, ph_d;
   logic [UNITCNT_W-1:0]   unit_q, unit_d;
   logic [BITCNT_W-1:0]    bit_q, bit_d;
   logic                   load_q, shclk_q;

   always_comb begin
      ph_d   = ph_q;
      unit_d = unit_q;
      bit_d  = bit_q;
      if (tick_i) begin
         case (ph_q)
            PH_REST: begin
               ph_d   = PH_LOAD;
               unit_d = '0;
            end
            PH_LOAD: begin
               if (unit_q == LAST_UNIT) begin
                  ph_d  = PH_SHIFT_LO;
                  bit_d = '0;
               end else begin
                  unit_d = unit_q + 1'b1;
               end
            end
            PH_SHIFT_LO: ph_d = PH_SHIFT_HI;
            PH_SHIFT_HI: begin
               if (bit_q == LAST_BIT) begin
                  ph_d = PH_REST;
               end else begin
                  bit_d = bit_q + 1'b1;
                  ph_d  = PH_SHIFT_LO;
               end
            end
            default: ph_d = PH_REST;
         endcase
      end
   end

   always_ff @(posedge clk or posedge arst) begin
      if (arst) begin
         ph_q    <= PH_REST;
         unit_q  <= '0;
         bit_q   <= '0;
         load_q  <= 1'b0;
         shclk_q <= 1'b1;
      end else begin
         ph_q    <= ph_d;
         unit_q  <= unit_d;
         bit_q   <= bit_d;
         load_q  <= (ph_d == PH_LOAD);
         shclk_q <= (ph_d != PH_SHIFT_LO);
      end
   end

   assign load_o   = load_q;
   assign shclk_o  = shclk_q;
   assign sample_o = tick_i && (ph_q == PH_SHIFT_LO);
   assign last_o   = sample_o && (bit_q == LAST_BIT);

   // R3
   low_only_unloaded_chk: assert property (@(posedge clk) disable iff (arst)
      !shclk_o |-> !load_o);
   // R3
   release_opens_pulse_chk: assert property (@(posedge clk) disable iff (arst)
      $fell(load_o) |-> $fell(shclk_o));
   // R5
   sample_at_rise_chk: assert property (@(posedge clk) disable iff (arst)
      sample_o |=> $rose(shclk_o));
   // R2
   load_on_tick_chk: assert property (@(posedge clk) disable iff (arst)
      $rose(load_o) |-> $past(tick_i));
endmodule

// File: rtl/gp_shifter.sv
module gp_shifter #(
   parameter int unsigned NUM_PADS   = 2,
   parameter int unsigned FRAME_BITS = 16,
   parameter int unsigned KEY_COUNT  = 12
) (
   input  logic                                  clk,
   input  logic                                  arst,
   input  logic                                  sample_i,
   input  logic [NUM_PADS-1:0]                   serial_i,
   output logic [NUM_PADS-1:0][KEY_COUNT-1:0]    word_o
);
   logic [NUM_PADS-1:0][FRAME_BITS-1:0] sr_q;

   for (genvar p = 0; p < NUM_PADS; p++) begin : g_lane
      always_ff @(posedge clk or posedge arst) begin
         if (arst) begin
            sr_q[p] <= '1;
         end else if (sample_i) begin
            sr_q[p] <= {serial_i[p], sr_q[p][FRAME_BITS-1:1]};
         end
      end
      assign word_o[p] = sr_q[p][KEY_COUNT-1:0];
   end

   // R5
   hold_between_samples_chk: assert property (@(posedge clk) disable iff (arst)
      !sample_i |=> $stable(sr_q));
endmodule

// File: rtl/gp_keyout.sv
module gp_keyout #(
   parameter int unsigned NUM_PADS        = 2,
   parameter int unsigned KEY_COUNT       = 12,
   parameter bit          OUT_ACTIVE_HIGH = 1'b1
) (
   input  logic                                clk,
   input  logic                                arst,
   input  logic                                load_i,
   input  logic [NUM_PADS-1:0][KEY_COUNT-1:0]  word_i,
   output logic [KEY_COUNT-1:0][NUM_PADS-1:0]  key_o
);
   logic [KEY_COUNT-1:0][NUM_PADS-1:0] pressed;
   logic [KEY_COUNT-1:0][NUM_PADS-1:0] level;
   logic [KEY_COUNT-1:0][NUM_PADS-1:0] key_q;
   logic [KEY_COUNT-1:0][NUM_PADS-1:0] idle_lvl;

   for (genvar k = 0; k < KEY_COUNT; k++) begin : g_key
      for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
         assign pressed[k][p] = ~word_i[p][k];
      end
   end

   if (OUT_ACTIVE_HIGH) begin : g_pos
      assign level    = pressed;
      assign idle_lvl = '0;
   end else begin : g_neg
      assign level    = ~pressed;
      assign idle_lvl = '1;
   end

   always_ff @(posedge clk or posedge arst) begin
      if (arst) begin
         key_q <= idle_lvl;
      end else if (load_i) begin
         key_q <= level;
      end
   end

   assign key_o = key_q;

   // R8
   key_update_chk: assert property (@(posedge clk) disable iff (arst)
      !$stable(key_o) |-> $past(load_i));
endmodule

// File: rtl/gamepad_poller.sv
module gamepad_poller
   import gp_poll_pkg::*;
#(
   parameter int unsigned NUM_PADS          = 2,
   parameter int unsigned TICKS_PER_UNIT    = 120,
   parameter bit          RESET_ACTIVE_HIGH = 1'b0,
   parameter bit          OUT_ACTIVE_HIGH   = 1'b1
) (
   input  logic                sys_clk,
   input  logic                sys_rst,
   input  logic [NUM_PADS-1:0] pad_serial,
   output logic                pad_load,
   output logic                pad_shift_clk,
   output logic [NUM_PADS-1:0] key_b,
   output logic [NUM_PADS-1:0] key_y,
   output logic [NUM_PADS-1:0] key_select,
   output logic [NUM_PADS-1:0] key_start,
   output logic [NUM_PADS-1:0] key_up,
   output logic [NUM_PADS-1:0] key_down,
   output logic [NUM_PADS-1:0] key_left,
   output logic [NUM_PADS-1:0] key_right,
   output logic [NUM_PADS-1:0] key_a,
   output logic [NUM_PADS-1:0] key_x,
   output logic [NUM_PADS-1:0] key_l,
   output logic [NUM_PADS-1:0] key_r
);
   localparam int unsigned SCNT_W = BITCNT_W + 1;

   if (NUM_PADS < 1) begin : g_bad_pads
      $error("gamepad_poller: NUM_PADS must be at least 1");
   end
   if (TICKS_PER_UNIT < 2) begin : g_bad_ticks
      $error("gamepad_poller: TICKS_PER_UNIT must be at least 2");
   end

   logic arst;
   if (RESET_ACTIVE_HIGH) begin : g_rst_hi
      assign arst = sys_rst;
   end else begin : g_rst_lo
      assign arst = ~sys_rst;
   end

   logic tick, sample, last, commit_q;
   logic [NUM_PADS-1:0][KEY_COUNT-1:0] word;
   logic [KEY_COUNT-1:0][NUM_PADS-1:0] key_vec;
   logic [SCNT_W-1:0] smp_cnt_q;

   gp_timebase #(
      .TICKS_PER_UNIT (TICKS_PER_UNIT)
   ) u_timebase (
      .clk    (sys_clk),
      .arst   (arst),
      .tick_o (tick)
   );

   gp_sequencer u_sequencer (
      .clk      (sys_clk),
      .arst     (arst),
      .tick_i   (tick),
      .load_o   (pad_load),
      .shclk_o  (pad_shift_clk),
      .sample_o (sample),
      .last_o   (last)
   );

   gp_shifter #(
      .NUM_PADS   (NUM_PADS),
      .FRAME_BITS (FRAME_BITS),
      .KEY_COUNT  (KEY_COUNT)
   ) u_shifter (
      .clk      (sys_clk),
      .arst     (arst),
      .sample_i (sample),
      .serial_i (pad_serial),
      .word_o   (word)
   );

   always_ff @(posedge sys_clk or posedge arst) begin
      if (arst) begin
         commit_q <= 1'b0;
      end else begin
         commit_q <= last;
      end
   end

   gp_keyout #(
      .NUM_PADS        (NUM_PADS),
      .KEY_COUNT       (KEY_COUNT),
      .OUT_ACTIVE_HIGH (OUT_ACTIVE_HIGH)
   ) u_keyout (
      .clk    (sys_clk),
      .arst   (arst),
      .load_i (commit_q),
      .word_i (word),
      .key_o  (key_vec)
   );

   assign key_b      = key_vec[KEY_B];
   assign key_y      = key_vec[KEY_Y];
   assign key_select = key_vec[KEY_SELECT];
   assign key_start  = key_vec[KEY_START];
   assign key_up     = key_vec[KEY_UP];
   assign key_down   = key_vec[KEY_DOWN];
   assign key_left   = key_vec[KEY_LEFT];
   assign key_right  = key_vec[KEY_RIGHT];
   assign key_a      = key_vec[KEY_A];
   assign key_x      = key_vec[KEY_X];
   assign key_l      = key_vec[KEY_L];
   assign key_r      = key_vec[KEY_R];

   always_ff @(posedge sys_clk or posedge arst) begin
      if (arst) begin
         smp_cnt_q <= '0;
      end else if (pad_load) begin
         smp_cnt_q <= '0;
      end else if (sample) begin
         smp_cnt_q <= smp_cnt_q + 1'b1;
      end
   end

   // R3
   sixteen_samples_chk: assert property (@(posedge sys_clk) disable iff (arst)
      last |-> (smp_cnt_q == SCNT_W'(FRAME_BITS - 1)));
   // R8
   commit_follows_last_chk: assert property (@(posedge sys_clk) disable iff (arst)
      $rose(commit_q) |-> $past(smp_cnt_q) == SCNT_W'(FRAME_BITS - 1));
endmodule

// File: tb/test_gamepad_poller.sv
`timescale 1ns/1ps
module test_gamepad_poller;
   localparam int NP = 3;
   localparam int TU = 3;
   localparam int FB = 16;
   localparam int NK = 12;
   localparam bit OUT_HI = 1'b1;

   logic sys_clk = 1'b0;
   logic sys_rst = 1'b0;
   logic [NP-1:0] pad_serial;
   logic pad_load, pad_shift_clk;
   logic [NP-1:0] key_b, key_y, key_select, key_start, key_up, key_down;
   logic [NP-1:0] key_left, key_right, key_a, key_x, key_l, key_r;

   always #2 sys_clk = ~sys_clk;

   gamepad_poller #(
      .NUM_PADS          (NP),
      .TICKS_PER_UNIT    (TU),
      .RESET_ACTIVE_HIGH (1'b0),
      .OUT_ACTIVE_HIGH   (OUT_HI)
   ) i_gamepad_poller (
      .sys_clk       (sys_clk),
      .sys_rst       (sys_rst),
      .pad_serial    (pad_serial),
      .pad_load      (pad_load),
      .pad_shift_clk (pad_shift_clk),
      .key_b         (key_b),
      .key_y         (key_y),
      .key_select    (key_select),
      .key_start     (key_start),
      .key_up        (key_up),
      .key_down      (key_down),
      .key_left      (key_left),
      .key_right     (key_right),
      .key_a         (key_a),
      .key_x         (key_x),
      .key_l         (key_l),
      .key_r         (key_r)
   );

   logic [NK*NP-1:0] keys_flat;
   assign keys_flat = {key_r, key_l, key_x, key_a, key_right, key_left,
                       key_down, key_up, key_start, key_select, key_y, key_b};

   // pad models: word bit k is presented during the k-th low phase
   logic [NP*FB-1:0] cur_words = '1;
   int pad_idx = 0;
   always @(posedge pad_load) pad_idx = 0;
   always @(posedge pad_shift_clk) if (!pad_load) pad_idx = pad_idx + 1;
   always_comb begin
      for (int p = 0; p < NP; p++) begin
         pad_serial[p] = (pad_idx < FB) ? cur_words[p*FB + pad_idx] : 1'b1;
      end
   end

   int n_chk = 0;
   int n_fail = 0;

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [NK*NP-1:0] decode(logic [NP*FB-1:0] w);
      logic [NK*NP-1:0] r;
      for (int k = 0; k < NK; k++) begin
         for (int p = 0; p < NP; p++) begin
            r[k*NP + p] = OUT_HI ? !w[p*FB + k] : w[p*FB + k];
         end
      end
      return r;
   endfunction

   function automatic logic [NK*NP-1:0] released();
      return OUT_HI ? '0 : '1;
   endfunction

   function automatic logic [NP*FB-1:0] fill(logic [15:0] w);
      logic [NP*FB-1:0] r;
      for (int p = 0; p < NP; p++) r[p*FB +: FB] = w;
      return r;
   endfunction

   // scoreboard
   logic [NP*FB-1:0] exp_q[$];
   logic [NP*FB-1:0] last_exp;
   bit have_last = 1'b0;
   int latch_seen = 0;

   task automatic send(logic [NP*FB-1:0] w);
      @(posedge pad_load);
      cur_words = w;
      exp_q.push_back(w);
   endtask

   initial begin
      forever begin
         @(posedge pad_load);
         @(negedge sys_clk);
         if (latch_seen == 0) begin
            check("R1 released before first commit", keys_flat, released());
         end else if (exp_q.size() > 0) begin
            last_exp = exp_q.pop_front();
            have_last = 1'b1;
            // R5 R6 R7 R9: frame decode per pad and button
            check("R5 R6 R7 R9 frame result", keys_flat, decode(last_exp));
         end
         latch_seen++;
      end
   end

   // timing monitor
   bit tim_en = 1'b0;
   bit prev_load = 1'b0, prev_clk = 1'b1;
   bit per_ok, l_ok, lo_ok, hi_ok, commit_pend;
   int per_cnt, lrun, lorun, hirun, rise_cnt;

   always @(negedge sys_clk) begin
      if (!tim_en) begin
         per_ok = 0; l_ok = 0; lo_ok = 0; hi_ok = 0; commit_pend = 0;
      end else begin
         if (commit_pend) begin
            commit_pend = 0;
            if (exp_q.size() > 0)
               check("R8 commit one cycle after last sample", keys_flat, decode(exp_q[0]));
         end
         if (pad_load && !prev_load) begin
            if (per_ok) begin
               check("R4 frame period", per_cnt, 35*TU);
               check("R3 pulses per frame", rise_cnt, 16);
            end
            per_ok = 1; per_cnt = 0; rise_cnt = 0; lrun = 0; l_ok = 1;
         end
         if (!pad_load && prev_load && l_ok)
            check("R2 load width", lrun, 2*TU);
         if (!pad_shift_clk && prev_clk) begin
            if (hi_ok)
               check("R3 high phase", hirun, (prev_load && !pad_load) ? 4*TU : TU);
            lorun = 0; lo_ok = 1;
         end
         if (pad_shift_clk && !prev_clk) begin
            if (lo_ok) check("R3 low phase", lorun, TU);
            rise_cnt++;
            hirun = 0; hi_ok = 1;
            if (rise_cnt == 16) begin
               check("R8 hold until commit", keys_flat,
                     have_last ? decode(last_exp) : released());
               commit_pend = 1;
            end
         end
         per_cnt++;
         if (pad_load) lrun++;
         if (!pad_shift_clk) lorun++;
         if (pad_shift_clk) hirun++;
      end
      prev_load = pad_load;
      prev_clk = pad_shift_clk;
   end

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #800000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [NP*FB-1:0] w;
      sys_rst = 1'b0;
      repeat (5) @(negedge sys_clk);
      // R1
      check("R1 reset keys", keys_flat, released());
      check("R1 reset load", pad_load, 1'b0);
      check("R1 reset shift clock", pad_shift_clk, 1'b1);
      sys_rst = 1'b1;
      tim_en = 1'b1;

      send(fill(16'hFFFF));
      send(fill(16'h0000));
      // R9: only the trailing bits low
      send(fill(16'h0FFF));
      for (int f = 0; f < NK; f++) begin
         for (int p = 0; p < NP; p++) w[p*FB +: FB] = ~(16'h1 << ((f + p) % NK));
         send(w);
      end
      // R7: different pattern per pad
      w[0*FB +: FB] = 16'hAAAA;
      w[1*FB +: FB] = 16'h5555;
      w[2*FB +: FB] = 16'h3C3C;
      send(w);
      send(fill(16'h0000));
      @(posedge pad_load);
      repeat (3) @(negedge sys_clk);

      // R10: asynchronous reset between clock edges, mid-load
      check("R10 pressed before reset", keys_flat, decode(fill(16'h0000)));
      tim_en = 1'b0;
      #1 sys_rst = 1'b0;
      #0.5;
      check("R10 async reset keys", keys_flat, released());
      check("R10 async reset load", pad_load, 1'b0);
      check("R10 async reset shift clock", pad_shift_clk, 1'b1);
      repeat (2) @(negedge sys_clk);
      sys_rst = 1'b1;
      repeat (2) @(negedge sys_clk);
      finish_run();
   end
endmodule